// File: doc/BRIEF.md
# Vectored interrupt priority arbiter

This block holds the interrupt state of a single core: a pending-request bitmap, an in-service bitmap and a trigger-mode bitmap, each covering 256 vectors. The bitmaps are stored as eight 32-bit words, and vector v lives in word v>>5 at bit v&31. A task priority register and the highest in-service vector together give a processor priority. A pending vector is offered to the core only when its 16-vector priority class is above that processor priority.

Requests arrive through an accept port that carries a vector and a trigger mode. The core takes the offered vector with a one-cycle acknowledge and later retires it with an end-of-interrupt strobe. When the retired vector was level-triggered, the block broadcasts a level end-of-interrupt carrying that vector. Accepting requests and offering them both depend on a hardware enable and a software enable.

Top module: `vec_prio_arb`

## Requirements
- R1: After reset all three bitmaps and the task priority are zero. int_pend is 0, ppr is 0x00 and leoi_valid is 0.
- R2: An accept (acc_valid) with hw_en and sw_en both high sets the request bit of acc_vector at the clock edge. In that same cycle acc_ok is 1 if the bit was clear.
- R3: An accept while hw_en or sw_en is low is dropped. acc_ok is 0 and no request is recorded.
- R4: An accept for a vector that is already pending is coalesced. acc_ok is 0, and one acknowledge retires the single request.
- R5: int_pend is 1 when both enables are high, a request is pending, and (highest pending vector AND 0xF0) is strictly greater than ppr. int_vec always shows the highest pending vector.
- R6: ppr equals the task priority when tpr[7:4] is at least the class (bits 7:4) of the highest in-service vector, with an empty in-service set counting as vector 0. Otherwise ppr equals that vector AND 0xF0.
- R7: ack_req while int_pend is 1 moves int_vec from the pending set to the in-service set at the clock edge. ppr reflects the change in the next cycle.
- R8: eoi clears the highest in-service vector. If that vector's trigger bit was set, the bit is cleared and leoi_valid is 1 with leoi_vec equal to the vector for exactly the cycle after the EOI edge. Otherwise no broadcast is made.
- R9: eoi with an empty in-service set changes nothing: there is no broadcast, ppr keeps its value, and the pending requests stay.
- R10: An accept with acc_level=1 sets the vector's trigger bit, and one with acc_level=0 clears it. This holds even when the request itself is coalesced.
- R11: When an accept and an acknowledge hit the same vector in the same cycle, the acknowledge is applied first. The vector ends up both in service and pending again, and acc_ok is 1.
- R12: int_pend is 0 whenever hw_en or sw_en is low, even with requests pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| acc_valid | input | 1 | Accept strobe |
| acc_vector | input | 8 | Vector to accept |
| acc_level | input | 1 | Trigger mode of the accept, 1 = level |
| acc_ok | output | 1 | Accept recorded as a new request this cycle |
| ack_req | input | 1 | Core takes the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write value |
| int_pend | output | 1 | An interrupt is offered |
| int_vec | output | 8 | Highest pending vector |
| ppr | output | 8 | Processor priority |
| leoi_valid | output | 1 | Level end-of-interrupt broadcast valid |
| leoi_vec | output | 8 | Vector of the level end-of-interrupt |

## Verification
Two functions can land in the same cycle on the same vector: an acknowledge, which clears a request bit, and an accept, which sets it. The bench provokes this by raising acc_valid for the very vector being acknowledged, while int_pend shows it. It judges the outcome from the ports alone. acc_ok must read 1, ppr must rise to the vector's class, and once the in-service copy is retired the vector must be offered again. The retire must also produce no level broadcast, because the edge accept overwrote the trigger bit.

// File: rtl/vpa_pkg.sv
// Package: shared constants and the trigger-mode type for the vectored
// interrupt priority arbiter.
package vpa_pkg;
    localparam int VPA_NVEC   = 256;  // number of vectors
    localparam int VPA_WORDW  = 32;   // bits per storage word
    localparam int VPA_CLASSW = 4;    // width of the priority class field

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/vpa_msb_find.sv
// Module: vpa_msb_find
// Finds the highest set bit of a vector, combinationally.
// Assumes W is a power of two. When no bit is set, idx is 0 and any is 0.
module vpa_msb_find #(
    parameter int W  = 256,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan upward so that the last set bit found is the highest one.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vpa_ppr_calc.sv
// Module: vpa_ppr_calc
// Derives the processor priority from the task priority and the highest
// in-service vector. Assumes CW < VW. An empty in-service set counts as
// vector 0.
module vpa_ppr_calc #(
    parameter int VW = 8,
    parameter int CW = 4
) (
    input  logic [VW-1:0] tpr,
    input  logic [VW-1:0] isr_top,
    input  logic          isr_any,
    output logic [VW-1:0] ppr
);
    localparam int LW = VW - CW;

    logic [CW-1:0] isr_cls;

    // Keep the task priority when its class is at least the in-service class.
    always_comb begin
        isr_cls = isr_any ? isr_top[VW-1:LW] : '0;
        if (tpr[VW-1:LW] >= isr_cls)
            ppr = tpr;
        else
            ppr = {isr_cls, LW'(0)};
    end
endmodule

// File: rtl/vpa_word_bank.sv
// Module: vpa_word_bank
// One storage word each of the pending, in-service and trigger bitmaps.
// Assumes the top decodes the word select lines. Within one cycle the
// clears from acknowledge and EOI are applied before the sets from accept,
// so a request raised in the same cycle is not lost.
module vpa_word_bank #(
    parameter int WORDW = 32,
    parameter int BW    = $clog2(WORDW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_ack,
    input  logic [BW-1:0]    ack_bit,
    input  logic             hit_eoi,
    input  logic [BW-1:0]    eoi_bit,
    input  logic             hit_acc,
    input  logic [BW-1:0]    acc_bit,
    input  vpa_pkg::trig_e   acc_trig,
    output logic [WORDW-1:0] irr,
    output logic [WORDW-1:0] isr,
    output logic [WORDW-1:0] tmr
);
    logic [WORDW-1:0] irr_n, isr_n, tmr_n;

    // Next state: clears first, then the accept's set.
    always_comb begin
        irr_n = irr;
        isr_n = isr;
        tmr_n = tmr;
        if (hit_ack) begin
            isr_n[ack_bit] = 1'b1;
            irr_n[ack_bit] = 1'b0;
        end
        if (hit_eoi) begin
            isr_n[eoi_bit] = 1'b0;
            tmr_n[eoi_bit] = 1'b0;
        end
        if (hit_acc) begin
            irr_n[acc_bit] = 1'b1;
            tmr_n[acc_bit] = (acc_trig == vpa_pkg::TRIG_LEVEL);
        end
    end

    // State registers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr <= '0;
            isr <= '0;
            tmr <= '0;
        end else begin
            irr <= irr_n;
            isr <= isr_n;
            tmr <= tmr_n;
        end
    end

    // R10: the trigger bit follows the trigger mode of the accept.
    a_r10_tmr_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        hit_acc |=> (tmr[$past(acc_bit)] == ($past(acc_trig) == vpa_pkg::TRIG_LEVEL)));

    // R7: an acknowledged bit is in service afterwards.
    a_r7_ack_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ack |=> isr[$past(ack_bit)]);
endmodule

// File: rtl/vec_prio_arb.sv
// Module: vec_prio_arb
// Vectored interrupt priority arbiter for one core. It holds the pending,
// in-service and trigger bitmaps, derives the processor priority, offers
// the highest pending vector, and retires vectors on EOI, broadcasting
// level EOIs. Assumes ack_req is raised only for one cycle per acknowledge
// and that the core samples int_vec in that same cycle.
module vec_prio_arb #(
    parameter int NVEC   = vpa_pkg::VPA_NVEC,
    parameter int WORDW  = vpa_pkg::VPA_WORDW,
    parameter int CLASSW = vpa_pkg::VPA_CLASSW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hw_en,
    input  logic                      sw_en,
    input  logic                      acc_valid,
    input  logic [$clog2(NVEC)-1:0]   acc_vector,
    input  logic                      acc_level,
    output logic                      acc_ok,
    input  logic                      ack_req,
    input  logic                      eoi,
    input  logic                      tpr_we,
    input  logic [$clog2(NVEC)-1:0]   tpr_wdata,
    output logic                      int_pend,
    output logic [$clog2(NVEC)-1:0]   int_vec,
    output logic [$clog2(NVEC)-1:0]   ppr,
    output logic                      leoi_valid,
    output logic [$clog2(NVEC)-1:0]   leoi_vec
);
    localparam int VW    = $clog2(NVEC);
    localparam int BW    = $clog2(WORDW);
    localparam int NWORD = NVEC / WORDW;
    localparam int SW    = VW - BW;
    localparam int LW    = VW - CLASSW;

    logic [NWORD-1:0][WORDW-1:0] irr_w, isr_w, tmr_w;
    logic [NVEC-1:0] irr_flat, isr_flat, tmr_flat;
    logic [VW-1:0]   irr_top, isr_top, tpr_q;
    logic            irr_any, isr_any;
    logic            en, ack_fire, eoi_fire, acc_fire, already, eoi_level;
    vpa_pkg::trig_e  acc_trig;

    assign irr_flat = irr_w;
    assign isr_flat = isr_w;
    assign tmr_flat = tmr_w;

    // Find the highest pending vector.
    vpa_msb_find #(.W(NVEC), .IW(VW)) u_irr_top (
        .bits(irr_flat), .idx(irr_top), .any(irr_any));

    // Find the highest in-service vector.
    vpa_msb_find #(.W(NVEC), .IW(VW)) u_isr_top (
        .bits(isr_flat), .idx(isr_top), .any(isr_any));

    // Derive the processor priority.
    vpa_ppr_calc #(.VW(VW), .CW(CLASSW)) u_ppr (
        .tpr(tpr_q), .isr_top(isr_top), .isr_any(isr_any), .ppr(ppr));

    // Offer, handshake and accept qualification.
    always_comb begin
        en        = hw_en & sw_en;
        int_vec   = irr_top;
        int_pend  = en & irr_any & ({irr_top[VW-1:LW], LW'(0)} > ppr);
        ack_fire  = ack_req & int_pend;
        eoi_fire  = eoi & isr_any;
        eoi_level = tmr_flat[isr_top];
        acc_fire  = acc_valid & en;
        already   = irr_flat[acc_vector] & ~(ack_fire && (int_vec == acc_vector));
        acc_ok    = acc_fire & ~already;
        acc_trig  = acc_level ? vpa_pkg::TRIG_LEVEL : vpa_pkg::TRIG_EDGE;
    end

    // One bank per storage word, selected by the upper vector bits.
    for (genvar w = 0; w < NWORD; w++) begin : g_word
        vpa_word_bank #(.WORDW(WORDW), .BW(BW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit_ack  (ack_fire && (int_vec[VW-1:BW] == SW'(w))),
            .ack_bit  (int_vec[BW-1:0]),
            .hit_eoi  (eoi_fire && (isr_top[VW-1:BW] == SW'(w))),
            .eoi_bit  (isr_top[BW-1:0]),
            .hit_acc  (acc_fire && (acc_vector[VW-1:BW] == SW'(w))),
            .acc_bit  (acc_vector[BW-1:0]),
            .acc_trig (acc_trig),
            .irr      (irr_w[w]),
            .isr      (isr_w[w]),
            .tmr      (tmr_w[w])
        );
    end

    // Task priority register.
    always_ff @(posedge clk) begin
        if (!rst_n)      tpr_q <= '0;
        else if (tpr_we) tpr_q <= tpr_wdata;
    end

    // Level EOI broadcast, registered for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leoi_valid <= 1'b0;
            leoi_vec   <= '0;
        end else begin
            leoi_valid <= eoi_fire & eoi_level;
            if (eoi_fire) leoi_vec <= isr_top;
        end
    end

    // R8: a broadcast only follows an EOI strobe.
    a_r8_leoi_after_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        leoi_valid |-> $past(eoi));

    // R9: an EOI with nothing in service gives no broadcast.
    a_r9_empty_eoi_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !isr_any) |=> !leoi_valid);

    // R3: a disabled accept is never reported as recorded.
    a_r3_drop_not_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !(hw_en && sw_en)) |-> !acc_ok);

    // R2: a qualified accept leaves its request bit set.
    a_r2_accept_sets: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fire |=> irr_flat[$past(acc_vector)]);

    // R7: an acknowledge clears the request unless it is raised again at once.
    a_r7_ack_clears_irr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !(acc_fire && (acc_vector == int_vec))) |=> !irr_flat[$past(int_vec)]);

    // R6: the processor priority never falls below the task priority.
    a_r6_ppr_floor: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= tpr_q);

    // R12: nothing is offered while disabled.
    a_r12_no_offer_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_en && sw_en) |-> !int_pend);
endmodule

// File: tb/sim_vec_prio_arb.sv
// Bench for vec_prio_arb: a table walk, then directed corner tests.
module sim_vec_prio_arb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b1, sw_en = 1'b1;
    logic       acc_valid = 1'b0, acc_level = 1'b0;
    logic [7:0] acc_vector = '0;
    logic       acc_ok;
    logic       ack_req = 1'b0, eoi = 1'b0, tpr_we = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic       int_pend, leoi_valid;
    logic [7:0] int_vec, ppr, leoi_vec;

    int checks = 0;
    int fails  = 0;
    bit last_ok;

    always #5 clk = ~clk;

    vec_prio_arb u0 (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
        .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_level(acc_level),
        .acc_ok(acc_ok), .ack_req(ack_req), .eoi(eoi), .tpr_we(tpr_we),
        .tpr_wdata(tpr_wdata), .int_pend(int_pend), .int_vec(int_vec),
        .ppr(ppr), .leoi_valid(leoi_valid), .leoi_vec(leoi_vec));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    // One-cycle operation: drive after a falling edge, hold through the
    // rising edge, sample two time units after it.
    task automatic op(input logic [1:0] kind, input logic [7:0] arg, input logic lvl);
        @(negedge clk);
        case (kind)
            2'd0: begin acc_valid = 1'b1; acc_vector = arg; acc_level = lvl; end
            2'd1: ack_req = 1'b1;
            2'd2: eoi = 1'b1;
            default: begin tpr_we = 1'b1; tpr_wdata = arg; end
        endcase
        #1 last_ok = acc_ok;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; ack_req = 1'b0; eoi = 1'b0; tpr_we = 1'b0;
        #1;
    endtask

    typedef struct packed {
        logic [1:0] kind;   // 0 accept, 1 ack, 2 eoi, 3 tpr write
        logic [7:0] arg;
        logic       lvl;
        logic       pend;
        logic [7:0] evec;
        logic [7:0] eppr;
        logic       leoi;
        logic [7:0] lvec;
    } row_t;

    localparam int NROW = 19;
    localparam row_t TBL [NROW] = '{
        '{2'd0, 8'h45, 1'b0, 1'b1, 8'h45, 8'h00, 1'b0, 8'h00},
        '{2'd0, 8'h92, 1'b1, 1'b1, 8'h92, 8'h00, 1'b0, 8'h00},
        '{2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'h90, 1'b0, 8'h00},
        '{2'd0, 8'hA1, 1'b0, 1'b1, 8'hA1, 8'h90, 1'b0, 8'h00},
        '{2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'hA0, 1'b0, 8'h00},
        '{2'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'h90, 1'b0, 8'h00},
        '{2'd2, 8'h00, 1'b0, 1'b1, 8'h45, 8'h00, 1'b1, 8'h92},
        '{2'd3, 8'h53, 1'b0, 1'b0, 8'h00, 8'h53, 1'b0, 8'h00},
        '{2'd3, 8'h3F, 1'b0, 1'b1, 8'h45, 8'h3F, 1'b0, 8'h00},
        '{2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'h40, 1'b0, 8'h00},
        '{2'd3, 8'h4C, 1'b0, 1'b0, 8'h00, 8'h4C, 1'b0, 8'h00},
        '{2'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'h4C, 1'b0, 8'h00},
        '{2'd3, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
        '{2'd0, 8'h20, 1'b1, 1'b1, 8'h20, 8'h00, 1'b0, 8'h00},
        '{2'd0, 8'hFF, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b0, 8'h00},
        '{2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'hF0, 1'b0, 8'h00},
        '{2'd2, 8'h00, 1'b0, 1'b1, 8'h20, 8'h00, 1'b0, 8'h00},
        '{2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'h20, 1'b0, 8'h00},
        '{2'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'h20}
    };

    bit done = 1'b0;

    initial begin
        #(2_000_000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        eq("R1 int_pend", int_pend, 0);
        eq("R1 ppr", ppr, 8'h00);
        eq("R1 leoi_valid", leoi_valid, 0);

        // Table walk: R2 R5 R6 R7 R8
        for (int i = 0; i < NROW; i++) begin
            if (TBL[i].kind == 2'd1) eq("R7 offered before ack", int_pend, 1);
            op(TBL[i].kind, TBL[i].arg, TBL[i].lvl);
            if (TBL[i].kind == 2'd0) eq("R2 acc_ok new", last_ok, 1);
            eq("R5 int_pend", int_pend, TBL[i].pend);
            if (TBL[i].pend) eq("R5 int_vec", int_vec, TBL[i].evec);
            eq("R6 ppr", ppr, TBL[i].eppr);
            eq("R8 leoi_valid", leoi_valid, TBL[i].leoi);
            if (TBL[i].leoi) eq("R8 leoi_vec", leoi_vec, TBL[i].lvec);
        end

        // R3: drop when either enable is low
        hw_en = 1'b0;
        op(2'd0, 8'h60, 1'b0);
        eq("R3 acc_ok hw off", last_ok, 0);
        hw_en = 1'b1;
        #1 eq("R3 nothing recorded hw", int_pend, 0);
        sw_en = 1'b0;
        op(2'd0, 8'h61, 1'b1);
        eq("R3 acc_ok sw off", last_ok, 0);
        sw_en = 1'b1;
        #1 eq("R3 nothing recorded sw", int_pend, 0);

        // R12: offer gated by enables
        op(2'd0, 8'h60, 1'b0);
        hw_en = 1'b0;
        #1 eq("R12 no offer hw off", int_pend, 0);
        hw_en = 1'b1;
        sw_en = 1'b0;
        #1 eq("R12 no offer sw off", int_pend, 0);
        sw_en = 1'b1;
        #1 eq("R12 offer restored", int_pend, 1);
        eq("R12 vector", int_vec, 8'h60);

        // R4: coalesced accept, one ack retires it
        op(2'd0, 8'h60, 1'b0);
        eq("R4 acc_ok coalesced", last_ok, 0);
        op(2'd1, 8'h00, 1'b0);
        eq("R4 single request retired", int_pend, 0);
        eq("R4 ppr in service", ppr, 8'h60);
        op(2'd2, 8'h00, 1'b0);
        eq("R4 edge eoi no broadcast", leoi_valid, 0);
        eq("R4 nothing left", int_pend, 0);

        // R11: accept and ack on the same vector in one cycle
        op(2'd0, 8'h70, 1'b1);
        @(negedge clk);
        acc_valid = 1'b1; acc_vector = 8'h70; acc_level = 1'b0; ack_req = 1'b1;
        #1 eq("R11 acc_ok same cycle", acc_ok, 1);
        @(posedge clk);
        #1 acc_valid = 1'b0; ack_req = 1'b0;
        #1;
        eq("R11 in service ppr", ppr, 8'h70);
        eq("R11 equal class not offered", int_pend, 0);
        op(2'd2, 8'h00, 1'b0);
        eq("R10 edge accept overwrote level", leoi_valid, 0);
        eq("R11 request survived", int_pend, 1);
        eq("R11 request vector", int_vec, 8'h70);
        op(2'd1, 8'h00, 1'b0);
        op(2'd2, 8'h00, 1'b0);
        eq("R11 drained", int_pend, 0);

        // R10: a coalesced edge accept still clears the trigger bit
        op(2'd0, 8'h33, 1'b1);
        op(2'd0, 8'h33, 1'b0);
        eq("R10 coalesced ok", last_ok, 0);
        op(2'd1, 8'h00, 1'b0);
        op(2'd2, 8'h00, 1'b0);
        eq("R10 edge after level", leoi_valid, 0);
        op(2'd0, 8'h34, 1'b1);
        op(2'd1, 8'h00, 1'b0);
        op(2'd2, 8'h00, 1'b0);
        eq("R10 level broadcast", leoi_valid, 1);
        eq("R8 level vector", leoi_vec, 8'h34);
        @(posedge clk);
        #2 eq("R8 one cycle only", leoi_valid, 0);

        // R9: EOI with empty in-service set
        op(2'd3, 8'h25, 1'b0);
        op(2'd0, 8'h10, 1'b0);
        eq("R5 below ppr not offered", int_pend, 0);
        op(2'd2, 8'h00, 1'b0);
        eq("R9 no broadcast", leoi_valid, 0);
        eq("R9 ppr kept", ppr, 8'h25);
        op(2'd3, 8'h00, 1'b0);
        eq("R9 request kept", int_pend, 1);
        eq("R9 request vector", int_vec, 8'h10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule